// File: doc/BRIEF.md
# Flash Page Write-Protection Checker

This block decides whether a pending flash program or page-erase lands on a write-protected page. Protection is set up as up to four segments. Each segment is a run of consecutive pages, given by a first page and a page count. The segment descriptors are held two to a 32-bit register, and software loads them through a small write/read port.

The command engine presents a 16-bit flash-component address with a request strobe. The address holds a 7-bit page, a 3-bit row and a 6-bit word. One clock later the checker returns three things:
- a valid flag;
- a per-segment hit vector;
- a single protected flag, which the engine uses to block the operation and raise its error.

A segment with a zero count is switched off. Segments may overlap. A segment whose end would pass the last page stops at page 127 and never wraps around to page 0.

Top module: `flash_page_wprot`

## Requirements
- R1: After reset both descriptor registers read zero, and `rsp_valid`, `rsp_prot` and `rsp_hit` are zero.
- R2: Register select 0 holds segment 0 in bits 15:0 and segment 1 in bits 31:16. Select 1 holds segment 2 in bits 15:0 and segment 3 in bits 31:16. Within each 16-bit descriptor, the first page sits in bits 14:8 and the page count in bits 6:0. A write stores the word with bits 31, 23, 15 and 7 forced to zero. `cfg_rdata` shows the selected register in the same cycle.
- R3: A segment whose page count is zero covers no page, whatever its first page is.
- R4: The target page is `req_addr[15:9]`. Segment i covers it exactly when first ≤ page < first + count, with the sum taken 8 bits wide. The row and word bits `req_addr[8:0]` have no effect.
- R5: Overlapping segments are allowed, and `rsp_prot` is 1 exactly when at least one bit of `rsp_hit` is 1.
- R6: A segment whose first page plus count exceeds 128 covers pages up to 127 only. Page 0 and other low pages are not covered by wrap-around.
- R7: `rsp_valid` is 1 in the cycle right after a cycle with `req_valid` high, and 0 otherwise. `rsp_prot` and `rsp_hit` are zero whenever `rsp_valid` is 0.
- R8: Bit i of `rsp_hit` reports coverage by segment i.
- R9: A request uses the descriptors held before the clock edge that samples it. A register write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the descriptor registers |
| cfg_sel | input | 1 | Register select (0: segments 0/1, 1: segments 2/3) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected register, combinational |
| req_valid | input | 1 | Check request strobe |
| req_addr | input | 16 | Component address: page[15:9], row[8:6], word[5:0] |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_prot | output | 1 | Target page is protected |
| rsp_hit | output | 4 | Per-segment coverage |

## Verification
Each check response is due on the first rising edge after the request strobe. It is visible for exactly one cycle. Register readback is combinational, while a register write takes effect at the edge that samples it.

The bench changes inputs on the falling edge. It samples a response at the next falling edge, after the single register stage. It samples one cycle later again to confirm that the outputs have returned to zero. The same-edge write test puts the request and the write in the same low phase, so both are sampled by one edge.

// File: rtl/flash_page_wprot.sv
module flash_page_wprot #(
  parameter int NSEG   = 4,
  parameter int PAGE_W = 7,
  parameter int ROW_W  = 3,
  parameter int WORD_W = 6,
  localparam int DESC_W = 2 * (PAGE_W + 1),
  localparam int REG_W  = 2 * DESC_W,
  localparam int NREG   = NSEG / 2,
  localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int ADDR_W = PAGE_W + ROW_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_prot,
  output logic [NSEG-1:0]   rsp_hit
);

  localparam int START_LSB = PAGE_W + 1;
  localparam logic [DESC_W-1:0] DESC_KEEP = {1'b0, {PAGE_W{1'b1}}, 1'b0, {PAGE_W{1'b1}}};

  logic [REG_W-1:0]  prot_q [NREG];
  logic [NSEG-1:0]   hit_c;
  logic [PAGE_W-1:0] page;
  logic              unused_addr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) prot_q[r] <= '0;
    end else if (cfg_wr) begin
      prot_q[cfg_sel] <= cfg_wdata & {2{DESC_KEEP}};
    end
  end

  assign cfg_rdata = prot_q[cfg_sel];

  assign page             = req_addr[ADDR_W-1 -: PAGE_W];
  assign unused_addr_bits = ^req_addr[ROW_W+WORD_W-1:0];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [DESC_W-1:0] desc;
    logic [PAGE_W-1:0] first;
    logic [PAGE_W-1:0] count;
    logic [PAGE_W:0]   stop;
    assign desc     = prot_q[s/2][(s%2)*DESC_W +: DESC_W];
    assign first    = desc[START_LSB +: PAGE_W];
    assign count    = desc[PAGE_W-1:0];
    assign stop     = {1'b0, first} + {1'b0, count};
    assign hit_c[s] = (count != '0) && (page >= first) && ({1'b0, page} < stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_hit   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_prot  <= req_valid && (|hit_c);
      rsp_hit   <= req_valid ? hit_c : '0;
    end
  end

endmodule

// File: rtl/page_wprot_sva.sv
module page_wprot_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_prot,
  input logic [3:0]  rsp_hit,
  input logic [31:0] cfg_rdata,
  input logic [31:0] prot_lo,
  input logic [31:0] prot_hi
);

  p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_without_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_prot && rsp_hit == 4'b0));

  p_prot_is_any_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_prot == (rsp_hit != 4'b0)));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[31] == 1'b0) && (cfg_rdata[23] == 1'b0) &&
    (cfg_rdata[15] == 1'b0) && (cfg_rdata[7] == 1'b0));

  p_zero_count_seg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_lo[6:0] == 7'd0) |=> !rsp_hit[0]);

  p_zero_count_seg3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_hi[22:16] == 7'd0) |=> !rsp_hit[3]);

  p_hit_above_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[15:9] < prot_lo[14:8]) |=> !rsp_hit[0]);

endmodule

bind flash_page_wprot page_wprot_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_prot  (rsp_prot),
  .rsp_hit   (rsp_hit),
  .cfg_rdata (cfg_rdata),
  .prot_lo   (prot_q[0]),
  .prot_hi   (prot_q[1])
);

// File: tb/sim_flash_page_wprot.sv
module sim_flash_page_wprot;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [0:0]  cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_prot;
  logic [3:0]  rsp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_page_wprot u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_prot(rsp_prot),
    .rsp_hit(rsp_hit)
  );

  localparam int NV = 19;
  // {reg0, reg1, address, expected hit}
  localparam logic [83:0] VEC [NV] = '{
    {32'h3C041808, 32'h00000000, 16'h3000, 4'h1},  // R4 first page of seg0
    {32'h3C041808, 32'h00000000, 16'h3FFF, 4'h1},  // R4 last page, row/word ones
    {32'h3C041808, 32'h00000000, 16'h4000, 4'h0},  // R4 one past end
    {32'h3C041808, 32'h00000000, 16'h2FFF, 4'h0},  // R4 one before start
    {32'h3C041808, 32'h00000000, 16'h7E00, 4'h2},  // R8 seg1 only
    {32'h3C041808, 32'h00000000, 16'h8000, 4'h0},
    {32'h00000000, 32'h00000000, 16'h0000, 4'h0},  // R3 all disabled
    {32'h05000500, 32'h05000500, 16'h0A00, 4'h0},  // R3 start set, count zero
    {32'h0F020A0A, 32'h007F1001, 16'h2000, 4'hF},  // R5 all overlap
    {32'h0F020A0A, 32'h007F1001, 16'hFE00, 4'h0},
    {32'h0F020A0A, 32'h007F1001, 16'h1E00, 4'hB},  // R5
    {32'h0F020A0A, 32'h007F1001, 16'h1400, 4'h9},  // R5
    {32'h00000000, 32'h7C7F0000, 16'hFFFF, 4'h8},  // R6 clamp at 127
    {32'h00000000, 32'h7C7F0000, 16'hF800, 4'h8},  // R6
    {32'h00000000, 32'h7C7F0000, 16'hF7FF, 4'h0},  // R6
    {32'h00000000, 32'h7C7F0000, 16'h0000, 4'h0},  // R6 no wrap
    {32'h00000000, 32'h00000001, 16'h0000, 4'h4},  // R8 seg2
    {32'h00000000, 32'h00000001, 16'h0200, 4'h0},
    {32'hBC849888, 32'h00000000, 16'h3000, 4'h1}   // R2 reserved bits dropped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ask(input logic [15:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 rsp_prot", {31'b0, rsp_prot}, 32'h0);
    check("R1 rsp_hit", {28'b0, rsp_hit}, 32'h0);
    cfg_sel = 1'b0; #1;
    check("R1 reg0", cfg_rdata, 32'h0);
    cfg_sel = 1'b1; #1;
    check("R1 reg1", cfg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][83:52]);
      wr(1'b1, VEC[i][51:20]);
      ask(VEC[i][19:4]);
      check($sformatf("R4 R7 vec%0d valid", i), {31'b0, rsp_valid}, 32'h1);
      check($sformatf("R8 vec%0d hit", i), {28'b0, rsp_hit}, {28'b0, VEC[i][3:0]});
      check($sformatf("R5 vec%0d prot", i), {31'b0, rsp_prot}, {31'b0, (VEC[i][3:0] != 4'h0)});
    end

    // R2 readback after reserved-bit write
    wr(1'b0, 32'hBC849888);
    cfg_sel = 1'b0; #1;
    check("R2 reserved masked", cfg_rdata, 32'h3C041808);
    wr(1'b1, 32'hFFFFFFFF);
    cfg_sel = 1'b1; #1;
    check("R2 reg1 all ones", cfg_rdata, 32'h7F7F7F7F);
    cfg_sel = 1'b0; #1;
    check("R2 reg0 untouched", cfg_rdata, 32'h3C041808);

    // R7 response lasts one cycle, outputs quiet afterwards
    ask(16'h3000);
    check("R7 valid pulse", {31'b0, rsp_valid}, 32'h1);
    @(negedge clk);
    check("R7 valid drops", {31'b0, rsp_valid}, 32'h0);
    check("R7 prot quiet", {31'b0, rsp_prot}, 32'h0);
    check("R7 hit quiet", {28'b0, rsp_hit}, 32'h0);

    // R7 back-to-back requests
    wr(1'b1, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h3000;
    @(negedge clk);
    req_addr = 16'h4000;
    check("R7 b2b first", {27'b0, rsp_valid, rsp_hit}, 32'h11);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 b2b second", {27'b0, rsp_valid, rsp_hit}, 32'h10);

    // R9 write on the same edge as the request
    wr(1'b0, 32'h0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h00000001;
    req_valid = 1'b1; req_addr = 16'h0000;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R9 old descriptors used", {27'b0, rsp_valid, rsp_hit}, 32'h10);
    ask(16'h0000);
    check("R9 new descriptors used", {27'b0, rsp_valid, rsp_hit}, 32'h11);

    // R1 reset mid-run clears registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_sel = 1'b0; #1;
    check("R1 reg0 after reset", cfg_rdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule